// File: doc/BRIEF.md
# Run-length stream expander

This block turns a stream of compressed capture words back into one sample per output beat. Each 32-bit word carries a tag in its top bit. A clear tag marks a literal, whose lower 31 bits are a new sample: the block emits it once and keeps it as the value to repeat. A set tag marks a run word, whose lower 31 bits say how many more times that kept value occurs. The block emits one beat for each of those repeats and sets a flag on every beat that comes from a run.

The input and the output both use valid/ready handshakes. A run word is taken in a single input handshake. The block then holds its input closed until the consumer has taken the last repeat beat of that run. Output backpressure can stall the stream for any number of cycles, and a held beat does not change while it waits. A one-cycle start pulse begins a new stream. It drops any beat in flight and any repeats still owed, clears the kept sample, and clears both sticky flags.

Two sticky flags report streams that break the format. An orphan error flag is set when a run word arrives before any literal since start. That run produces no beats. A protocol-warning flag is set when a run word directly follows another run word. The second run is still expanded from the kept value. A run count of zero produces no beats.

Top module: `rle_expander`

## Requirements
- R1: After reset, and in the cycle after a start pulse, out_valid is 0, in_ready is 1, and err_orphan and warn_double are 0.
- R2: A literal word (bit 31 = 0) accepted on a handshake appears on the next cycle as exactly one beat. That beat has out_sample = bits 30:0 and out_rep = 0.
- R3: A run word (bit 31 = 1) with count N = bits 30:0 > 0, accepted after a literal, produces exactly N beats after that literal. Each of these beats carries the most recent literal's value and has out_rep = 1.
- R4: While repeat beats of a run remain untaken, in_ready stays 0 whatever out_ready is.
- R5: While out_valid is 1 and out_ready is 0, the beat stays valid with out_sample and out_rep unchanged, and in_ready is 0.
- R6: A run word accepted before any literal since start or reset produces no beat and sets err_orphan. err_orphan stays set until the next start or reset.
- R7: A run word with count 0 produces no beat.
- R8: A run word accepted directly after another run word sets warn_double, which stays set until start or reset. That run is still expanded from the kept literal.
- R9: A start pulse drops a pending beat and any repeats still owed, and clears both flags. A run word that follows before any new literal is then treated as an orphan.
- R10: With input always valid and output always ready, beats leave back to back with no idle cycle. A literal waiting behind a run is emitted in the cycle after the final repeat beat. A stream of L literals and R repeats therefore finishes in L+R+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a new stream |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_word | input | 32 | Compressed word: bit 31 is the tag, bits 30:0 are the sample or the count |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_sample | output | 31 | Expanded sample |
| out_rep | output | 1 | Beat comes from a run expansion |
| err_orphan | output | 1 | Sticky: run word seen before any literal |
| warn_double | output | 1 | Sticky: two run words in a row |

## Verification
The checker watches several behaviours on every cycle. A stalled beat must stay valid and unchanged. No word may be accepted while a beat is stalled. Each accepted literal must appear on the next cycle, and every repeat beat must carry the kept sample. A run with no literal before it must produce no beat, and both flags must stay set once raised. Some properties need the history of a whole stream and are left to the bench scenarios: the exact number of repeat beats per run, the order of beats across mixed streams under random backpressure, what start clears, and the back-to-back timing at full rate.

// File: rtl/rle_pkg.sv
package rle_pkg;
   typedef enum logic [1:0] {
      WK_LITERAL  = 2'd0,
      WK_RUN      = 2'd1,
      WK_ZERO_RUN = 2'd2
   } word_kind_e;
endpackage

// File: rtl/rle_word_class.sv
module rle_word_class #(
   parameter int SAMPLE_W = 31
) (
   input  logic [SAMPLE_W:0]    word,
   output rle_pkg::word_kind_e  kind,
   output logic [SAMPLE_W-1:0]  payload
);
   logic tag;
   assign tag     = word[SAMPLE_W];
   assign payload = word[SAMPLE_W-1:0];

   always_comb begin
      if (!tag)               kind = rle_pkg::WK_LITERAL;
      else if (payload == '0) kind = rle_pkg::WK_ZERO_RUN;
      else                    kind = rle_pkg::WK_RUN;
   end
endmodule

// File: rtl/rle_run_counter.sv
module rle_run_counter #(
   parameter int CNT_W = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             remain_nz
);
   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear)  remain_q <= '0;
      else if (load)        remain_q <= load_val;
      else if (dec)         remain_q <= remain_q - 1'b1;
   end

   assign remain_nz = (remain_q != '0);
endmodule

// File: rtl/rle_history.sv
module rle_history #(
   parameter int SAMPLE_W = 31
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                lit_take,
   input  logic [SAMPLE_W-1:0] lit_val,
   input  logic                run_take,
   output logic [SAMPLE_W-1:0] kept_sample,
   output logic                kept_valid,
   output logic                err_orphan,
   output logic                warn_double
);
   logic last_was_run;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         kept_sample  <= '0;
         kept_valid   <= 1'b0;
         last_was_run <= 1'b0;
         err_orphan   <= 1'b0;
         warn_double  <= 1'b0;
      end else if (lit_take) begin
         kept_sample  <= lit_val;
         kept_valid   <= 1'b1;
         last_was_run <= 1'b0;
      end else if (run_take) begin
         last_was_run <= 1'b1;
         if (!kept_valid)  err_orphan  <= 1'b1;
         if (last_was_run) warn_double <= 1'b1;
      end
   end
endmodule

// File: rtl/rle_expander.sv
module rle_expander #(
   parameter int SAMPLE_W = 31
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W:0]   in_word,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [SAMPLE_W-1:0] out_sample,
   output logic                out_rep,
   output logic                err_orphan,
   output logic                warn_double
);
   localparam int CNT_W = SAMPLE_W;

   if (SAMPLE_W < 2) begin : g_width_bad
      $error("rle_expander: SAMPLE_W must be at least 2");
   end

   rle_pkg::word_kind_e   kind;
   logic [SAMPLE_W-1:0]   payload;
   logic [SAMPLE_W-1:0]   hist_sample;
   logic                  hist_valid;
   logic                  remain_nz;
   logic                  accept, take;
   logic                  lit_take, run_take, run_load;

   rle_word_class #(.SAMPLE_W(SAMPLE_W)) u_class (
      .word    (in_word),
      .kind    (kind),
      .payload (payload)
   );

   assign in_ready = !start && !remain_nz && (!out_valid || out_ready);
   assign accept   = in_valid && in_ready;
   assign take     = out_valid && out_ready;
   assign lit_take = accept && (kind == rle_pkg::WK_LITERAL);
   assign run_take = accept && (kind != rle_pkg::WK_LITERAL);
   assign run_load = accept && (kind == rle_pkg::WK_RUN) && hist_valid;

   rle_history #(.SAMPLE_W(SAMPLE_W)) u_hist (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (start),
      .lit_take    (lit_take),
      .lit_val     (payload),
      .run_take    (run_take),
      .kept_sample (hist_sample),
      .kept_valid  (hist_valid),
      .err_orphan  (err_orphan),
      .warn_double (warn_double)
   );

   rle_run_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (start),
      .load      (run_load),
      .load_val  (payload - 1'b1),
      .dec       (take && remain_nz),
      .remain_nz (remain_nz)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || start) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
         out_rep    <= 1'b0;
      end else if (lit_take) begin
         out_valid  <= 1'b1;
         out_sample <= payload;
         out_rep    <= 1'b0;
      end else if (run_load) begin
         out_valid  <= 1'b1;
         out_sample <= hist_sample;
         out_rep    <= 1'b1;
      end else if (run_take) begin
         out_valid  <= 1'b0;
      end else if (take) begin
         out_valid  <= remain_nz;
      end
   end
endmodule

// File: rtl/rle_expander_chk.sv
module rle_expander_chk #(
   parameter int SAMPLE_W = 31
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                in_valid,
   input logic                in_ready,
   input logic [SAMPLE_W:0]   in_word,
   input logic                out_valid,
   input logic                out_ready,
   input logic [SAMPLE_W-1:0] out_sample,
   input logic                out_rep,
   input logic                err_orphan,
   input logic                warn_double,
   input logic [SAMPLE_W-1:0] hist_sample,
   input logic                hist_valid
);
   // R5
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n || start)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) && $stable(out_rep)));

   // R5
   no_accept_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R2
   literal_echo_chk: assert property (@(posedge clk) disable iff (!rst_n || start)
      (in_valid && in_ready && !in_word[SAMPLE_W]) |=>
      (out_valid && !out_rep && out_sample == $past(in_word[SAMPLE_W-1:0])));

   // R3
   repeat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_rep) |-> (hist_valid && out_sample == hist_sample));

   // R6
   orphan_silent_chk: assert property (@(posedge clk) disable iff (!rst_n || start)
      (in_valid && in_ready && in_word[SAMPLE_W] && !hist_valid) |=> (!out_valid && err_orphan));

   // R6
   orphan_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || start)
      err_orphan |=> err_orphan);

   // R8
   warn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || start)
      warn_double |=> warn_double);
endmodule

bind rle_expander rle_expander_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .in_word     (in_word),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_sample  (out_sample),
   .out_rep     (out_rep),
   .err_orphan  (err_orphan),
   .warn_double (warn_double),
   .hist_sample (hist_sample),
   .hist_valid  (hist_valid)
);

// File: tb/rle_expander_test.sv
module rle_expander_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_word = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [30:0] out_sample;
   logic        out_rep;
   logic        err_orphan;
   logic        warn_double;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   rle_expander uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_sample(out_sample), .out_rep(out_rep),
      .err_orphan(err_orphan), .warn_double(warn_double)
   );

   // reference model state
   logic [30:0] exp_s[$];
   bit          exp_r[$];
   logic [31:0] words[$];
   logic [30:0] m_kept;
   bit          m_have, m_last_run, m_err, m_warn;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      m_kept = '0; m_have = 0; m_last_run = 0; m_err = 0; m_warn = 0;
      exp_s.delete(); exp_r.delete(); words.delete();
   endtask

   task automatic model_word(logic [31:0] w);
      words.push_back(w);
      if (!w[31]) begin
         exp_s.push_back(w[30:0]); exp_r.push_back(1'b0);
         m_kept = w[30:0]; m_have = 1; m_last_run = 0;
      end else begin
         if (m_last_run) m_warn = 1;
         if (!m_have) m_err = 1;
         else for (int k = 0; k < int'(w[30:0]); k++) begin
            exp_s.push_back(m_kept); exp_r.push_back(1'b1);
         end
         m_last_run = 1;
      end
   endtask

   task automatic drv(bit v, logic [31:0] w, bit r, bit s);
      @(negedge clk);
      in_valid = v; in_word = w; out_ready = r; start = s;
      #1;
   endtask

   task automatic pulse_start();
      drv(0, '0, 0, 1);
      drv(0, '0, 0, 0);
   endtask

   task automatic run_stream(int p_valid, int p_ready, output int cyc);
      int idx = 0;
      bit acc, tk;
      logic [30:0] es;
      bit er;
      cyc = 0;
      while (!(idx == words.size() && exp_s.size() == 0) && cyc < 20000) begin
         @(negedge clk);
         start = 0;
         in_valid = (idx < words.size()) && (($urandom % 100) < p_valid);
         in_word = (idx < words.size()) ? words[idx] : '0;
         out_ready = ($urandom % 100) < p_ready;
         #1;
         acc = in_valid && in_ready;
         tk = out_valid && out_ready;
         if (tk) begin
            if (exp_s.size() == 0) begin
               chk(0, "R3", "unexpected beat", out_sample, 0);
            end else begin
               es = exp_s.pop_front(); er = exp_r.pop_front();
               chk(out_sample == es, er ? "R3" : "R2", "beat sample", out_sample, es);
               chk(out_rep == er, er ? "R3" : "R2", "beat rep flag", out_rep, er);
            end
         end
         if (acc) idx++;
         cyc++;
      end
      chk(exp_s.size() == 0, "R3", "beats left over", exp_s.size(), 0);
      drv(0, '0, 0, 0);
      chk(err_orphan == m_err, "R6", "orphan flag after stream", err_orphan, m_err);
      chk(warn_double == m_warn, "R8", "double-run flag after stream", warn_double, m_warn);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      int cyc;
      logic [31:0] w;
      void'($urandom(32'd20250611));
      repeat (3) @(posedge clk);
      drv(0, '0, 0, 0);
      rst_n = 1'b1;
      drv(0, '0, 0, 0);
      // R1 reset state
      chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
      chk(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
      chk(err_orphan == 0 && warn_double == 0, "R1", "flags after reset",
          {err_orphan, warn_double}, 0);

      // R2 literal, R5 stall
      drv(1, 32'h1234_5678, 0, 0);
      chk(in_ready == 1, "R2", "ready for literal", in_ready, 1);
      drv(0, '0, 0, 0);
      chk(out_valid && out_sample == 31'h1234_5678 && !out_rep, "R2", "literal beat",
          out_sample, 31'h1234_5678);
      for (int i = 0; i < 2; i++) begin
         drv(1, 32'h8000_0003, 0, 0);
         chk(out_valid && out_sample == 31'h1234_5678, "R5", "held beat", out_sample, 31'h1234_5678);
         chk(in_ready == 0, "R5", "in_ready during stall", in_ready, 0);
      end
      drv(1, 32'h8000_0003, 1, 0);
      // R4 repeats pending
      drv(1, 32'h0000_0042, 1, 0);
      chk(out_valid && out_rep && out_sample == 31'h1234_5678, "R3", "repeat beat", out_sample,
          31'h1234_5678);
      chk(in_ready == 0, "R4", "in_ready with repeats owed", in_ready, 0);
      drv(1, 32'h0000_0042, 1, 0);
      chk(in_ready == 0, "R4", "in_ready with one repeat owed", in_ready, 0);
      drv(0, '0, 0, 0);
      chk(out_valid && out_rep, "R3", "last repeat held", out_valid, 1);
      // R9 start drops it
      pulse_start();
      chk(out_valid == 0 && in_ready == 1, "R9", "start drops beat", out_valid, 0);

      // R6 orphan run
      drv(1, 32'h8000_0002, 1, 0);
      drv(0, '0, 1, 0);
      chk(out_valid == 0, "R6", "orphan run silent", out_valid, 0);
      chk(err_orphan == 1, "R6", "orphan flag set", err_orphan, 1);
      drv(1, 32'h0000_0007, 1, 0);
      drv(0, '0, 0, 0);
      chk(err_orphan == 1 && out_valid == 1, "R6", "orphan flag sticky", err_orphan, 1);
      pulse_start();
      chk(err_orphan == 0, "R9", "start clears orphan flag", err_orphan, 0);
      // R9 kept sample cleared: run after start is orphan
      drv(1, 32'h8000_0001, 1, 0);
      drv(0, '0, 1, 0);
      chk(out_valid == 0 && err_orphan == 1, "R9", "run after start is orphan", err_orphan, 1);
      pulse_start();

      // R7 zero count, R8 second run sets warning
      drv(1, 32'h0000_0055, 1, 0);
      drv(1, 32'h8000_0000, 1, 0);
      drv(0, '0, 1, 0);
      chk(out_valid == 0, "R7", "zero count silent", out_valid, 0);
      chk(warn_double == 0, "R8", "single run no warning", warn_double, 0);
      drv(1, 32'h8000_0002, 1, 0);
      drv(0, '0, 0, 0);
      chk(warn_double == 1, "R8", "double run warning", warn_double, 1);
      chk(out_valid && out_rep && out_sample == 31'h55, "R8", "double run still expands",
          out_sample, 31'h55);
      pulse_start();

      // R10 full rate timing: literal, run 2, literal -> 4 beats in 5 cycles
      model_clear();
      model_word(32'h0000_0AAA); model_word(32'h8000_0002); model_word(32'h0000_0BBB);
      run_stream(100, 100, cyc);
      chk(cyc == 5, "R10", "cycles at full rate", cyc, 5);
      pulse_start();

      // random streams under several handshake mixes
      for (int s = 0; s < 8; s++) begin
         model_clear();
         for (int i = 0; i < 60; i++) begin
            int r = $urandom % 10;
            if (r < 6) w = {1'b0, 31'($urandom)};
            else if (r < 9) w = {1'b1, 31'(1 + $urandom % 6)};
            else w = 32'h8000_0000;
            model_word(w);
         end
         run_stream((s % 2) ? 100 : 60, (s < 4) ? 50 : 90, cyc);
         pulse_start();
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule